// File: doc/BRIEF.md
# Board Rail Power-Up Sequencer

This block brings a board's supply rails up in a fixed order. It is a synchronous state machine that walks through four states. In IDLE it waits for the base supplies. In the first rail stage it switches on three secondary regulators and waits for their power-good signals. In the second rail stage it waits for the last supply. In the ready state every rail is up.

Once the machine is ready, it releases the PCIe reset, enables the 200 MHz reference clock and lets a debounced push button drive the FPGA program line. If any power-good signal that the current state depends on goes away, the machine falls back to IDLE at once. It drops the rail enables and then climbs the ladder again from the start.

Every asynchronous input passes through a two-flop synchronizer. The current state is exported so that a status-LED block can show it.

Top module: `rail_sequencer`

## Requirements
- R1: `state_o` encodes IDLE=0, PS1=1, PS2=2, RDY=3. The state only ever moves up by exactly one step per clock, or drops to IDLE.
- R2: IDLE leaves for PS1 only when `pg_core_a`, `pg_core_b` and `pg_aux4v` are all high.
- R3: `en_1v8`, `en_3v3m` and `en_vadj` are high in PS1, PS2 and RDY, and low in IDLE.
- R4: PS1 moves to PS2 only when `pg_1v8`, `pg_3v3m` and `pg_vadj` are all high.
- R5: PS2 moves to RDY only when `pg_1v5` is high.
- R6: In PS1, PS2 or RDY, losing any power-good input that an earlier stage required sends the machine to IDLE. A power-good input that no stage so far has required has no effect.
- R7: `pcie_rst_n` is low and `clk200_en` is low in every state except RDY. In RDY both are high.
- R8: `prog_n` is high outside RDY. In RDY, `prog_n` is the inverse of the debounced button level, where a high `btn` means pressed.
- R9: The debounced button level changes only after the synchronized button has held the new level for `DEBOUNCE_CYCLES` consecutive clocks. In total, `prog_n` responds `DEBOUNCE_CYCLES`+3 clock edges after a pin change. A pulse shorter than `DEBOUNCE_CYCLES` clocks is ignored.
- R10: A power-good pin change reaches `state_o` and the registered outputs on the third rising clock edge after it: two synchronizer stages, then the state register.
- R11: `vadj_sel` always carries the fixed parameter code `VADJ_CODE` that selects 1.8 V (default 3'b011).
- R12: A synchronous active-high `rst` forces IDLE, rail enables low, `pcie_rst_n` low, `clk200_en` low and `prog_n` high on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pg_core_a | input | 1 | Power-good, first 1 V supply |
| pg_core_b | input | 1 | Power-good, second 1 V supply |
| pg_aux4v | input | 1 | Power-good, 4 V supply |
| pg_1v8 | input | 1 | Power-good, 1.8 V rail |
| pg_3v3m | input | 1 | Power-good, 3.3 V mezzanine rail |
| pg_vadj | input | 1 | Power-good, adjustable mezzanine rail |
| pg_1v5 | input | 1 | Power-good, 1.5 V supply |
| btn | input | 1 | Raw push button, high when pressed |
| en_1v8 | output | 1 | Enable for 1.8 V regulator |
| en_3v3m | output | 1 | Enable for 3.3 V mezzanine regulator |
| en_vadj | output | 1 | Enable for adjustable mezzanine regulator |
| vadj_sel | output | 3 | Voltage select code for adjustable rail |
| pcie_rst_n | output | 1 | PCIe reset, active low |
| clk200_en | output | 1 | 200 MHz reference clock enable |
| prog_n | output | 1 | FPGA program line, active low |
| state_o | output | 2 | Current sequencer state for status display |

## Verification
The bench sweeps all 128 power-good combinations, both from reset and after a drop out of RDY. This catches a design that gates a stage on the wrong group of rails, or that ignores a lost rail and stays in RDY. It also catches a design that wrongly reacts to a late-stage rail before that rail is needed.

The bench checks the fall through IDLE at the exact cycle. A design that goes straight back to an intermediate state would skip the rail-enable drop. It also times the edge at which a state change first appears, which exposes a missing or extra synchronizer stage.

For the button, the bench uses a pulse one cycle shorter than the debounce window and a press of exactly the window's length. An off-by-one counter either passes the glitch or delays the press. A press held before RDY must show on `prog_n` only once RDY is reached.

// File: rtl/rseq_pkg.sv
package rseq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PS1  = 2'd1,
    ST_PS2  = 2'd2,
    ST_RDY  = 2'd3
  } seq_state_e;

  // Power-good vector bit positions
  localparam int PG_W       = 7;
  localparam int PG_CORE_A  = 0;
  localparam int PG_CORE_B  = 1;
  localparam int PG_AUX4V   = 2;
  localparam int PG_1V8     = 3;
  localparam int PG_3V3M    = 4;
  localparam int PG_VADJ    = 5;
  localparam int PG_1V5     = 6;

  // Groups gating each step of the ladder
  localparam logic [PG_W-1:0] GRP_BASE  = 7'b0000111;
  localparam logic [PG_W-1:0] GRP_RAILS = 7'b0111000;
  localparam logic [PG_W-1:0] GRP_LATE  = 7'b1000000;

  // Rails that must stay good while sitting in a given state
  function automatic logic [PG_W-1:0] held_mask(input seq_state_e st);
    case (st)
      ST_PS1:  held_mask = GRP_BASE;
      ST_PS2:  held_mask = GRP_BASE | GRP_RAILS;
      ST_RDY:  held_mask = GRP_BASE | GRP_RAILS | GRP_LATE;
      default: held_mask = '0;
    endcase
  endfunction

endpackage

// File: rtl/rseq_sync.sv
module rseq_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/rseq_debounce.sv
module rseq_debounce #(
  parameter int CYCLES = 2_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] run_cnt;
  logic          level_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
      level_q <= 1'b0;
    end else if (din == level_q) begin
      run_cnt <= '0;
    end else if (run_cnt == LAST) begin
      run_cnt <= '0;
      level_q <= din;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  assign dout = level_q;

endmodule

// File: rtl/rseq_fsm.sv
module rseq_fsm
  import rseq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [PG_W-1:0] pg,
  input  logic            btn_level,
  output logic            rails_en,
  output logic            pcie_rst_n,
  output logic            clk_en,
  output logic            prog_n,
  output seq_state_e      state
);

  seq_state_e state_q, state_d;
  logic       held_ok;

  assign held_ok = ((pg & held_mask(state_q)) == held_mask(state_q));

  always_comb begin
    state_d = state_q;
    if (!held_ok) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: if ((pg & GRP_BASE)  == GRP_BASE)  state_d = ST_PS1;
        ST_PS1:  if ((pg & GRP_RAILS) == GRP_RAILS) state_d = ST_PS2;
        ST_PS2:  if ((pg & GRP_LATE)  == GRP_LATE)  state_d = ST_RDY;
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      rails_en   <= 1'b0;
      pcie_rst_n <= 1'b0;
      clk_en     <= 1'b0;
      prog_n     <= 1'b1;
    end else begin
      state_q    <= state_d;
      rails_en   <= (state_d != ST_IDLE);
      pcie_rst_n <= (state_d == ST_RDY);
      clk_en     <= (state_d == ST_RDY);
      prog_n     <= (state_d == ST_RDY) ? ~btn_level : 1'b1;
    end
  end

  assign state = state_q;

endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer
  import rseq_pkg::*;
#(
  parameter int          SYNC_STAGES     = 2,
  parameter int          DEBOUNCE_CYCLES = 2_000_000,
  parameter logic [2:0]  VADJ_CODE       = 3'b011
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pg_core_a,
  input  logic       pg_core_b,
  input  logic       pg_aux4v,
  input  logic       pg_1v8,
  input  logic       pg_3v3m,
  input  logic       pg_vadj,
  input  logic       pg_1v5,
  input  logic       btn,
  output logic       en_1v8,
  output logic       en_3v3m,
  output logic       en_vadj,
  output logic [2:0] vadj_sel,
  output logic       pcie_rst_n,
  output logic       clk200_en,
  output logic       prog_n,
  output logic [1:0] state_o
);

  localparam int IN_W = PG_W + 1;

  logic [IN_W-1:0] raw_in, sync_in;
  logic            btn_level;
  logic            rails_en;
  seq_state_e      state;

  always_comb begin
    raw_in            = '0;
    raw_in[PG_CORE_A] = pg_core_a;
    raw_in[PG_CORE_B] = pg_core_b;
    raw_in[PG_AUX4V]  = pg_aux4v;
    raw_in[PG_1V8]    = pg_1v8;
    raw_in[PG_3V3M]   = pg_3v3m;
    raw_in[PG_VADJ]   = pg_vadj;
    raw_in[PG_1V5]    = pg_1v5;
    raw_in[PG_W]      = btn;
  end

  rseq_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (sync_in)
  );

  rseq_debounce #(.CYCLES(DEBOUNCE_CYCLES)) u_db (
    .clk  (clk),
    .rst  (rst),
    .din  (sync_in[PG_W]),
    .dout (btn_level)
  );

  rseq_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .pg         (sync_in[PG_W-1:0]),
    .btn_level  (btn_level),
    .rails_en   (rails_en),
    .pcie_rst_n (pcie_rst_n),
    .clk_en     (clk200_en),
    .prog_n     (prog_n),
    .state      (state)
  );

  always_ff @(posedge clk) begin
    if (rst) vadj_sel <= VADJ_CODE;
    else     vadj_sel <= VADJ_CODE;
  end

  assign en_1v8  = rails_en;
  assign en_3v3m = rails_en;
  assign en_vadj = rails_en;
  assign state_o = state;

endmodule

// File: rtl/rseq_checker.sv
module rseq_checker #(
  parameter logic [2:0] VADJ_CODE = 3'b011
) (
  input logic       clk,
  input logic       rst,
  input logic       en_1v8,
  input logic       en_3v3m,
  input logic       en_vadj,
  input logic [2:0] vadj_sel,
  input logic       pcie_rst_n,
  input logic       clk200_en,
  input logic       prog_n,
  input logic [1:0] state_o
);

  p_step_or_drop_r1: assert property (@(posedge clk) disable iff (rst)
    (state_o != $past(state_o)) |-> ((state_o == $past(state_o) + 2'd1) || (state_o == 2'd0)));

  p_rails_follow_state_r3: assert property (@(posedge clk) disable iff (rst)
    (en_1v8 == (state_o != 2'd0)) && (en_3v3m == en_1v8) && (en_vadj == en_1v8));

  p_reset_and_clock_r7: assert property (@(posedge clk) disable iff (rst)
    (pcie_rst_n == (state_o == 2'd3)) && (clk200_en == (state_o == 2'd3)));

  p_prog_idle_outside_rdy_r8: assert property (@(posedge clk) disable iff (rst)
    (state_o != 2'd3) |-> prog_n);

  p_vsel_fixed_r11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) == 1'b0 |-> vadj_sel == VADJ_CODE);

  p_reset_safe_r12: assert property (@(posedge clk)
    $past(rst) |-> (state_o == 2'd0) && !en_1v8 && !pcie_rst_n && !clk200_en && prog_n);

endmodule

bind rail_sequencer rseq_checker #(.VADJ_CODE(VADJ_CODE)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .en_1v8     (en_1v8),
  .en_3v3m    (en_3v3m),
  .en_vadj    (en_vadj),
  .vadj_sel   (vadj_sel),
  .pcie_rst_n (pcie_rst_n),
  .clk200_en  (clk200_en),
  .prog_n     (prog_n),
  .state_o    (state_o)
);

// File: tb/tb_rail_sequencer.sv
module tb_rail_sequencer;

  localparam int         DB   = 8;
  localparam logic [2:0] VSEL = 3'b011;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [6:0] pg = '0;
  logic btn = 1'b0;
  logic en_1v8, en_3v3m, en_vadj, pcie_rst_n, clk200_en, prog_n;
  logic [2:0] vadj_sel;
  logic [1:0] state_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rail_sequencer #(.DEBOUNCE_CYCLES(DB), .VADJ_CODE(VSEL)) dut (
    .clk(clk), .rst(rst),
    .pg_core_a(pg[0]), .pg_core_b(pg[1]), .pg_aux4v(pg[2]),
    .pg_1v8(pg[3]), .pg_3v3m(pg[4]), .pg_vadj(pg[5]), .pg_1v5(pg[6]),
    .btn(btn),
    .en_1v8(en_1v8), .en_3v3m(en_3v3m), .en_vadj(en_vadj),
    .vadj_sel(vadj_sel), .pcie_rst_n(pcie_rst_n), .clk200_en(clk200_en),
    .prog_n(prog_n), .state_o(state_o)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] settle(input logic [6:0] c);
    if (c[2:0] != 3'b111) return 2'd0;
    if (c[5:3] != 3'b111) return 2'd1;
    if (!c[6])            return 2'd2;
    return 2'd3;
  endfunction

  // Output set implied by a state with the button released
  task automatic chk_outs(input string req, input logic [1:0] st);
    chk({req, " state"}, state_o, st);
    chk("R3 enables", {en_1v8, en_3v3m, en_vadj}, (st != 0) ? 3'b111 : 3'b000);
    chk("R7 pcie/clk", {pcie_rst_n, clk200_en}, (st == 3) ? 2'b11 : 2'b00);
    chk("R8 prog_n released", prog_n, 1'b1);
    chk("R11 vadj_sel", vadj_sel, VSEL);
  endtask

  initial begin
    step(3);
    chk_outs("R12 in reset", 2'd0);
    rst = 1'b0;
    step(2);
    chk_outs("R12 after reset", 2'd0);

    // R10: latency of a power-good change
    pg = 7'b0000111;
    step(2);
    chk("R10 not yet", state_o, 2'd0);
    step(1);
    chk("R10 third edge", state_o, 2'd1);
    chk("R3 enables on PS1", en_1v8, 1'b1);

    // R2 R4 R5: exhaustive sweep from reset
    for (int c = 0; c < 128; c++) begin
      rst = 1'b1; pg = 7'(c);
      step(1);
      rst = 1'b0;
      step(9);
      chk_outs("R2 R4 R5 sweep from reset", settle(7'(c)));
    end

    // R6: every combination dropped into from RDY
    for (int c = 0; c < 128; c++) begin
      pg = 7'h7f;
      step(10);
      chk("R5 back in RDY", state_o, 2'd3);
      pg = 7'(c);
      step(3);
      chk("R6 drop to IDLE", state_o, (c == 127) ? 2'd3 : 2'd0);
      chk("R6 rails off on drop", en_1v8, (c == 127) ? 1'b1 : 1'b0);
      step(8);
      chk_outs("R6 R1 resettle", settle(7'(c)));
    end

    // R6: late rail not required in PS1
    pg = 7'b0000111; step(8);
    chk("R6 PS1 hold", state_o, 2'd1);
    pg = 7'b1000111; step(5);
    pg = 7'b0000111; step(5);
    chk("R6 late rail ignored in PS1", state_o, 2'd1);

    // R8 R9: button in RDY
    pg = 7'h7f; step(10);
    chk("R8 RDY", state_o, 2'd3);
    btn = 1'b1; step(DB - 1);
    btn = 1'b0; step(20);
    chk("R9 short pulse ignored", prog_n, 1'b1);
    btn = 1'b1; step(DB + 2);
    chk("R9 before window ends", prog_n, 1'b1);
    step(1);
    chk("R9 R8 press drives prog_n low", prog_n, 1'b0);
    btn = 1'b0; step(DB + 2);
    chk("R9 release pending", prog_n, 1'b0);
    step(1);
    chk("R9 release", prog_n, 1'b1);

    // R8: press held before RDY
    pg = 7'b0111111; step(10);
    chk("R8 PS2", state_o, 2'd2);
    btn = 1'b1; step(DB + 10);
    chk("R8 prog_n held outside RDY", prog_n, 1'b1);
    pg = 7'h7f; step(2);
    chk("R8 still PS2", prog_n, 1'b1);
    step(1);
    chk("R8 RDY reached", state_o, 2'd3);
    chk("R8 pressed shows in RDY", prog_n, 1'b0);

    // R12: reset from RDY
    rst = 1'b1; step(1);
    chk("R12 reset state", state_o, 2'd0);
    chk("R12 reset prog_n", prog_n, 1'b1);
    chk("R12 reset pcie", pcie_rst_n, 1'b0);
    btn = 1'b0; rst = 1'b0;
    step(12);
    chk_outs("R1 R12 recover", 2'd3);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule